// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Compare Toggle Output

This block is a 16-bit up-counter with four operating modes selected by a two-bit field in a byte-wide control register. When the field is 00 the counter is stopped and held at zero. Otherwise it counts every clock. In free-running mode it simply wraps. In external-restart mode it returns to zero on a chosen edge of an asynchronous event input. In compare-restart mode it returns to zero when it equals compare register 0.

Two 16-bit compare registers drive a toggle output. The output flips whenever the counter equals either compare value. A condition bit in the control register adds the external edge as a third toggle source. A sticky wrap flag is raised whenever the counter passes from FFFFh to 0000h. Software can set or clear this flag through the control register. Software also selects the active edge of the event input in a small separate register.

The registers sit behind a simple write-strobe/address port with a combinational read path.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register reads 00h, and the counter, toggle output and wrap flag are 0. While the mode field (control bits 3:2) is 00, the counter is held at 0 and the toggle output keeps its level.
- R2: With mode 01, the counter advances by one on every clock and wraps from FFFFh to 0000h.
- R3: With mode 10, a valid edge on `evt_in` clears the counter. The edge passes two synchronizer flops and one edge flop, so the counter reads 0 after the third rising clock edge that follows the input change. Without an edge the counter counts up.
- R4: With mode 11, when the counter equals compare register 0 it reads 0 one clock later, so the count period is compare value + 1.
- R5: In every counting mode, a pass of the counter from FFFFh to 0000h sets the wrap flag (control bit 0). This holds even when a restart happens in the same cycle.
- R6: Writing the control register with bit 0 = 1 sets the wrap flag, and with bit 0 = 0 clears it. A write whose mode field is 00 leaves the flag at 0 whatever bit 0 holds. A hardware wrap in the same cycle as a write with a nonzero mode field sets the flag.
- R7: In any counting mode the toggle output inverts one clock after a cycle in which the counter equals compare register 0 or compare register 1. It inverts only once when both match.
- R8: With the condition bit (control bit 1) at 1, a valid `evt_in` edge also inverts the toggle output. At 0 it does not.
- R9: Register map by `addr`: 0 is control (bits 7:4 and 15:4 read 0), 1 is edge select (bits 1:0), 2 is compare 0, 3 is compare 1, 4 is the counter (read only). A write takes effect at the next clock.
- R10: Edge-select codes: 00 is falling, 01 is rising, 10 is never, 11 is either edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| evt_in | input | 1 | Asynchronous external event input |
| tgl_out | output | 1 | Toggle output |
| count_o | output | 16 | Current counter value |
| wrap_flag_o | output | 1 | Sticky wrap flag |

## Verification
A register write shows on the outputs after one clock. A counter value equal to a compare register changes the counter (mode 11) and the toggle output one clock later. An `evt_in` change acts three clocks later, through the synchronizer and the edge flop. The bench drives inputs and compares outputs on the falling clock edge. A reference model steps once per rising edge using the inputs held over the preceding half period, so every result is compared exactly in the cycle it is due. This includes the wrap coinciding with a compare restart at FFFFh.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_FREE   = 2'b01,
    MODE_EXTCLR = 2'b10,
    MODE_CMPCLR = 2'b11
  } tmr_mode_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_ESEL = 3'd1;
  localparam logic [2:0] A_CMP0 = 3'd2;
  localparam logic [2:0] A_CMP1 = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  // edge qualifier: older sample, newer sample
  function automatic logic edge_hit(input logic [1:0] sel, input logic older, input logic newer);
    case (sel)
      2'b00:   edge_hit = older & ~newer;
      2'b01:   edge_hit = ~older & newer;
      2'b11:   edge_hit = older ^ newer;
      default: edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_timer16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  localparam int TAPS = SYNC_STAGES + 1;
  logic [TAPS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= async_i;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  assign edge_o = edge_hit(sel_i, sh_q[TAPS-1], sh_q[TAPS-2]);
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic en, input logic rs);
    next_count = (!en || rs) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= next_count(cnt_o, en_i, restart_i);
  end

  assign wrap_o = en_i && (cnt_o == {W{1'b1}});

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/evt_toggle.sv
module evt_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hit0_i,
  input  logic hit1_i,
  input  logic ext_i,
  input  logic ext_ok_i,
  output logic tgl_o
);
  logic flip;
  assign flip = en_i && (hit0_i || hit1_i || (ext_ok_i && ext_i));

  always_ff @(posedge clk) begin
    if (!rst_n)    tgl_o <= 1'b0;
    else if (flip) tgl_o <= ~tgl_o;
  end

  p_hold_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(tgl_o));
  p_match_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (hit0_i || hit1_i)) |=> (tgl_o != $past(tgl_o)));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         evt_in,
  output logic         tgl_out,
  output logic [W-1:0] count_o,
  output logic         wrap_flag_o
);
  tmr_mode_e   mode_q;
  logic        cond_q;
  logic        flag_q;
  logic [1:0]  esel_q;
  logic [W-1:0] cmp0_q, cmp1_q;

  logic ctrl_wr, en, ext_edge, hit0, hit1, restart, wrap_evt;
  tmr_mode_e mode_nx;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign en      = (mode_q != MODE_OFF);
  assign hit0    = (count_o == cmp0_q);
  assign hit1    = (count_o == cmp1_q);
  assign restart = ((mode_q == MODE_EXTCLR) && ext_edge) ||
                   ((mode_q == MODE_CMPCLR) && hit0);
  assign mode_nx = ctrl_wr ? tmr_mode_e'(wr_data[3:2]) : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cond_q <= 1'b0;
      esel_q <= 2'b00;
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          mode_q <= tmr_mode_e'(wr_data[3:2]);
          cond_q <= wr_data[1];
        end
        A_ESEL:  esel_q <= wr_data[1:0];
        A_CMP0:  cmp0_q <= wr_data;
        A_CMP1:  cmp1_q <= wr_data;
        default: ;
      endcase
    end
  end

  // sticky wrap flag: mode 00 forces 0, hardware wrap wins over a write of 0
  always_ff @(posedge clk) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (mode_nx == MODE_OFF) flag_q <= 1'b0;
    else                          flag_q <= (ctrl_wr ? wr_data[0] : flag_q) | wrap_evt;
  end

  evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_i(evt_in), .sel_i(esel_q), .edge_o(ext_edge));

  evt_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(en), .restart_i(restart),
    .cnt_o(count_o), .wrap_o(wrap_evt));

  evt_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .hit0_i(hit0), .hit1_i(hit1),
    .ext_i(ext_edge), .ext_ok_i(cond_q), .tgl_o(tgl_out));

  assign wrap_flag_o = flag_q;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data[3:0] = {mode_q, cond_q, flag_q};
      A_ESEL:  rd_data[1:0] = esel_q;
      A_CMP0:  rd_data = cmp0_q;
      A_CMP1:  rd_data = cmp1_q;
      A_CNT:   rd_data = count_o;
      default: rd_data = '0;
    endcase
  end

  p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |=> (count_o == '0));
  p_free_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE) |=> (count_o == $past(count_o) + 1'b1));
  p_ext_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_EXTCLR) && ext_edge) |=> (count_o == '0));
  p_cmp_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_CMPCLR) && (count_o == cmp0_q)) |=> (count_o == '0));
  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !(ctrl_wr && wr_data[3:2] == 2'b00)) |=> wrap_flag_o);
endmodule

// File: tb/evt_timer16_tb.sv
module evt_timer16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        evt_in = 1'b0;
  logic        tgl_out;
  logic [15:0] count_o;
  logic        wrap_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .tgl_out(tgl_out), .count_o(count_o),
    .wrap_flag_o(wrap_flag_o));

  // reference model state
  int m_mode, m_oc, m_flag, m_esel, m_c0, m_c1, m_cnt, m_tgl;
  int s1, s2, s3;

  always @(posedge clk) begin
    int hit, en, mt0, mt1, rs, wr, nmode, nf;
    if (!rst_n) begin
      m_mode = 0; m_oc = 0; m_flag = 0; m_esel = 0; m_c0 = 0; m_c1 = 0;
      m_cnt = 0; m_tgl = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      case (m_esel)
        0: hit = (s3 == 1 && s2 == 0);
        1: hit = (s3 == 0 && s2 == 1);
        3: hit = (s3 != s2);
        default: hit = 0;
      endcase
      en  = (m_mode != 0);
      mt0 = (m_cnt == m_c0);
      mt1 = (m_cnt == m_c1);
      rs  = (m_mode == 2 && hit) || (m_mode == 3 && mt0);
      wr  = (en && m_cnt == 65535);
      nmode = m_mode;
      nf = m_flag;
      if (wr_en && addr == 0) begin nmode = wr_data[3:2]; nf = wr_data[0]; end
      nf = (nmode == 0) ? 0 : (nf || wr);
      if (en && (mt0 || mt1 || (m_oc && hit))) m_tgl = !m_tgl;
      m_cnt = (!en || rs) ? 0 : (m_cnt + 1) % 65536;
      m_flag = nf;
      if (wr_en) begin
        if (addr == 0) begin m_mode = wr_data[3:2]; m_oc = wr_data[1]; end
        if (addr == 1) m_esel = wr_data[1:0];
        if (addr == 2) m_c0 = wr_data;
        if (addr == 3) m_c1 = wr_data;
      end
      s3 = s2; s2 = s1; s1 = evt_in;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R3/R4 counter", count_o, m_cnt);
      chk("R7/R8 toggle", tgl_out, m_tgl);
      chk("R5/R6 wrap flag", wrap_flag_o, m_flag);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd4;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    addr = 3'(a);
    #1;
    chk(tag, rd_data, exp);
    addr = 3'd4;
  endtask

  task automatic pulse(input int hi, input int lo);
    evt_in = 1'b1; cyc(hi);
    evt_in = 1'b0; cyc(lo);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    rd("R1 reset control", 0, 0);
    chk("R1 reset counter", count_o, 0);
    chk("R1 reset toggle", tgl_out, 0);
    chk("R1 reset flag", wrap_flag_o, 0);

    // free-running with two compare points
    wr(2, 10); wr(3, 20);
    rd("R9 compare0 readback", 2, 10);
    rd("R9 compare1 readback", 3, 20);
    wr(0, 16'h04);
    cyc(60);
    rd("R9 counter readback", 4, m_cnt);
    // both compares equal: single toggle
    wr(3, 70);
    wr(2, 70);
    cyc(40);

    // disable: counter held 0, toggle held
    wr(0, 16'h00);
    cyc(6);
    chk("R1 disabled counter", count_o, 0);
    chk("R1 disabled toggle level", tgl_out, m_tgl);

    // compare restart
    wr(2, 9); wr(3, 4);
    wr(0, 16'h0C);
    cyc(45);

    // external restart, rising edge, no toggle on edge
    wr(1, 1);
    wr(0, 16'h08);
    cyc(30);
    pulse(5, 20);
    // condition bit on, each edge select
    wr(0, 16'h0A);
    pulse(4, 15);
    wr(1, 0);
    pulse(4, 15);
    wr(1, 3);
    pulse(4, 15);
    wr(1, 2);
    cyc(5);
    pulse(3, 10);
    chk("R10 reserved select never restarts", (count_o > 25) ? 1 : 0, 1);
    rd("R9 edge select readback", 1, 2);
    // timing of a restart: third rising edge after the change
    wr(1, 1);
    cyc(10);
    evt_in = 1'b1;
    cyc(2);
    chk("R3 not yet cleared after two clocks", (count_o != 0) ? 1 : 0, 1);
    cyc(1);
    chk("R3 cleared on third clock", count_o, 0);
    evt_in = 1'b0;
    cyc(5);

    // software flag access
    wr(0, 16'h05);
    chk("R6 software set", wrap_flag_o, 1);
    wr(0, 16'h04);
    chk("R6 software clear", wrap_flag_o, 0);
    wr(0, 16'h05);
    wr(0, 16'h01);
    chk("R6 mode 00 clears flag", wrap_flag_o, 0);
    wr(0, 16'hFF);
    rd("R9 control upper bits zero", 0, 16'h000F);

    // wrap coinciding with compare restart
    wr(0, 16'h00);
    wr(3, 16'h8000);
    wr(2, 16'hFFFF);
    wr(0, 16'h0C);
    cyc(65545);
    chk("R5 wrap with restart sets flag", wrap_flag_o, 1);

    // free-running wrap
    wr(0, 16'h00);
    wr(0, 16'h04);
    cyc(65545);
    chk("R5 free-running wrap sets flag", wrap_flag_o, 1);
    chk("R2 wrapped counter small", (count_o < 20) ? 1 : 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule